// File: doc/BRIEF.md
# Static Mesh Router with Preloaded Routes

A mesh router for deterministic traffic between cores. Routes are worked out before the run and loaded once. The router has four neighbour links (north, east, south, west) and one attached core. Each outgoing link is driven by its own registered 4-to-1 selector. The four choices are the core's send register for that direction and the three other incoming links. Nothing is buffered and nothing is arbitrated, so a word entering the router leaves on the next clock edge or not at all. Transfers that share no link pass through at the same time.

The core side is a set of eight registers, one send and one receive register per neighbour direction. A core writes a word into the send register for a direction, and the router may carry it out on that direction's link. Each incoming link is captured into the matching receive register. The payload is opaque to the router. Packets made of an address word, data words and a control word with source, destination, length and check fields are carried one word per cycle.

Configuration goes through a small write port. A write carries a target output, a 2-bit selector and an enable bit. Several outputs may name the same source, which gives fan-out. Writing a different source over an output that is already enabled in the current route set counts as an attempt to merge two sources onto one destination. Such a write raises a sticky error. A clear command starts a new route set.

Top module: `static_mesh_router`

## Requirements
- R1: While reset is asserted and right after it, every link output and every receive register shows valid low and data zero, cfgError is low, and all outputs are disabled.
- R2: Direction codes are north 0, east 1, south 2, west 3. A configuration write (cfgWrEn high) stores cfgSel and cfgEn for output cfgDir at the next edge. For output d, selector 0 picks the core's send register d, and selector s from 1 to 3 picks incoming link (d+s) mod 4.
- R3: An output that is disabled, or whose selected source is not valid, drives valid low and data zero, whatever its inputs carry.
- R4: A valid word on an incoming link at one edge appears unchanged on every enabled output selecting that link at the next edge, a latency of one cycle.
- R5: Fan-out is supported: one source selected by several outputs appears on all of them in the same cycle.
- R6: A core write to send register d (coreSendWr bit d) loads it at the next edge. When output d selects 0, the word leaves on link d one edge later. Each write yields exactly one valid cycle, and a word written for one direction never appears on another direction's link.
- R7: Each incoming link d is captured into receive register d at the next edge. Valid follows the link's valid, and data is zero when the link is not valid.
- R8: A write with cfgEn high to an output that is already enabled with a different selector sets cfgError, which then stays set. Rewriting the same selector or disabling an output does not set it.
- R9: cfgClear disables all outputs and clears cfgError at the next edge, and it overrides a configuration write in the same cycle.
- R10: All four outputs carry independent transfers in the same cycle when their sources are distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgDir | input | 2 | Output direction being configured |
| cfgSel | input | 2 | Selector value for that output |
| cfgEn | input | 1 | Enable for that output |
| cfgClear | input | 1 | Start a new route set: disable all, clear error |
| cfgError | output | 1 | Sticky merge-attempt error |
| linkInValid | input | 4 | Valid flag of each incoming link |
| linkInData | input | 4*DATA_W | Incoming link words, direction d at bits d*DATA_W upward |
| linkOutValid | output | 4 | Valid flag of each outgoing link |
| linkOutData | output | 4*DATA_W | Outgoing link words, same packing |
| coreSendWr | input | 4 | Core write strobe per send register |
| coreSendData | input | 4*DATA_W | Core words for the send registers |
| coreRecvValid | output | 4 | Valid flag of each receive register |
| coreRecvData | output | 4*DATA_W | Receive register contents |

## Verification
The hardest situations to reach from the ports involve the configuration state. One is a write that collides with an output already enabled in the same route set. Another is a clear that arrives in the very cycle of a write. The stimulus first builds a full route set and then rewrites one output with its own selector, which must stay silent. It then disables an output, and finally writes a different selector over an enabled output. Before the pending write the bench checks each step, both through cfgError and through traffic driven on the links. For the clear-and-write case, both strobes are raised together, and the bench then shows at the ports that the written route never carries data.

// File: rtl/smr_pkg.sv
package smr_pkg;
  localparam int NUM_DIR = 4;
  localparam int SEL_W   = $clog2(NUM_DIR);

  typedef logic [SEL_W-1:0] dirCode_t;

  // strobes handed from the configuration control to the datapath
  typedef struct packed {
    logic [NUM_DIR-1:0]            outEn;
    logic [NUM_DIR-1:0][SEL_W-1:0] outSel;
  } routeCfg_t;
endpackage

// File: rtl/smr_cfg_ctrl.sv
module smr_cfg_ctrl
  import smr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWrEn,
  input  dirCode_t  cfgDir,
  input  dirCode_t  cfgSel,
  input  logic      cfgEn,
  input  logic      cfgClear,
  output routeCfg_t routeCfg,
  output logic      cfgError
);
  logic mergeTry;

  // a second, different source aimed at an output already in use
  assign mergeTry = cfgWrEn && cfgEn && routeCfg.outEn[cfgDir]
                    && (routeCfg.outSel[cfgDir] != cfgSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeCfg <= '0;
      cfgError <= 1'b0;
    end else if (cfgClear) begin
      routeCfg <= '0;
      cfgError <= 1'b0;
    end else if (cfgWrEn) begin
      routeCfg.outEn[cfgDir]  <= cfgEn;
      routeCfg.outSel[cfgDir] <= cfgSel;
      if (mergeTry) cfgError <= 1'b1;
    end
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgClear) |=> (routeCfg.outEn[$past(cfgDir)] == $past(cfgEn))
                               && (routeCfg.outSel[$past(cfgDir)] == $past(cfgSel)));
  a_r8_merge_flags: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgEn && !cfgClear && routeCfg.outEn[cfgDir]
     && routeCfg.outSel[cfgDir] != cfgSel) |=> cfgError);
  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (cfgError && !cfgClear) |=> cfgError);
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    cfgClear |=> (!cfgError && routeCfg.outEn == '0));
endmodule

// File: rtl/smr_out_mux.sv
module smr_out_mux
  import smr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIR_IDX = 0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           en,
  input  dirCode_t                       sel,
  input  logic                           localValid,
  input  logic [DATA_W-1:0]              localData,
  input  logic [NUM_DIR-1:0]             linkInValid,
  input  logic [NUM_DIR-1:0][DATA_W-1:0] linkInData,
  output logic                           outValid,
  output logic [DATA_W-1:0]              outData
);
  localparam dirCode_t DIR_CODE = dirCode_t'(DIR_IDX);

  dirCode_t          srcIdx;
  logic              pickValid;
  logic [DATA_W-1:0] pickData;

  // selector s>0 walks clockwise from this output's own direction
  assign srcIdx = DIR_CODE + sel;

  always_comb begin
    if (sel == '0) begin
      pickValid = localValid;
      pickData  = localData;
    end else begin
      pickValid = linkInValid[srcIdx];
      pickData  = linkInData[srcIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= en && pickValid;
      outData  <= (en && pickValid) ? pickData : '0;
    end
  end

  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (!outValid && outData == '0));
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> outData == '0);
  a_r4_one_cycle_hop: assert property (@(posedge clk) disable iff (!rstN)
    (en && sel != '0 && linkInValid[srcIdx]) |=>
      (outValid && outData == $past(linkInData[srcIdx])));
  a_r6_local_path: assert property (@(posedge clk) disable iff (!rstN)
    (en && sel == '0 && localValid) |=> (outValid && outData == $past(localData)));
endmodule

// File: rtl/smr_datapath.sv
module smr_datapath
  import smr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  routeCfg_t                      routeCfg,
  input  logic [NUM_DIR-1:0]             linkInValid,
  input  logic [NUM_DIR-1:0][DATA_W-1:0] linkInData,
  output logic [NUM_DIR-1:0]             linkOutValid,
  output logic [NUM_DIR-1:0][DATA_W-1:0] linkOutData,
  input  logic [NUM_DIR-1:0]             coreSendWr,
  input  logic [NUM_DIR-1:0][DATA_W-1:0] coreSendData,
  output logic [NUM_DIR-1:0]             coreRecvValid,
  output logic [NUM_DIR-1:0][DATA_W-1:0] coreRecvData
);
  logic [NUM_DIR-1:0]             sendValid;
  logic [NUM_DIR-1:0][DATA_W-1:0] sendData;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sendValid[d]     <= 1'b0;
        sendData[d]      <= '0;
        coreRecvValid[d] <= 1'b0;
        coreRecvData[d]  <= '0;
      end else begin
        sendValid[d]     <= coreSendWr[d];
        sendData[d]      <= coreSendWr[d] ? coreSendData[d] : '0;
        coreRecvValid[d] <= linkInValid[d];
        coreRecvData[d]  <= linkInValid[d] ? linkInData[d] : '0;
      end
    end

    smr_out_mux #(.DATA_W(DATA_W), .DIR_IDX(d)) u_out_mux (
      .clk         (clk),
      .rstN        (rstN),
      .en          (routeCfg.outEn[d]),
      .sel         (routeCfg.outSel[d]),
      .localValid  (sendValid[d]),
      .localData   (sendData[d]),
      .linkInValid (linkInValid),
      .linkInData  (linkInData),
      .outValid    (linkOutValid[d]),
      .outData     (linkOutData[d])
    );

    a_r7_recv_capture: assert property (@(posedge clk) disable iff (!rstN)
      linkInValid[d] |=> (coreRecvValid[d] && coreRecvData[d] == $past(linkInData[d])));
    a_r6_send_one_shot: assert property (@(posedge clk) disable iff (!rstN)
      !coreSendWr[d] |=> !sendValid[d]);
  end
endmodule

// File: rtl/static_mesh_router.sv
module static_mesh_router
  import smr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrEn,
  input  logic [1:0]                cfgDir,
  input  logic [1:0]                cfgSel,
  input  logic                      cfgEn,
  input  logic                      cfgClear,
  output logic                      cfgError,
  input  logic [3:0]                linkInValid,
  input  logic [4*DATA_W-1:0]       linkInData,
  output logic [3:0]                linkOutValid,
  output logic [4*DATA_W-1:0]       linkOutData,
  input  logic [3:0]                coreSendWr,
  input  logic [4*DATA_W-1:0]       coreSendData,
  output logic [3:0]                coreRecvValid,
  output logic [4*DATA_W-1:0]       coreRecvData
);
  routeCfg_t                      routeCfg;
  logic [NUM_DIR-1:0][DATA_W-1:0] inWords, outWords, sendWords, recvWords;

  assign inWords      = linkInData;
  assign sendWords    = coreSendData;
  assign linkOutData  = outWords;
  assign coreRecvData = recvWords;

  smr_cfg_ctrl u_cfg_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgDir   (cfgDir),
    .cfgSel   (cfgSel),
    .cfgEn    (cfgEn),
    .cfgClear (cfgClear),
    .routeCfg (routeCfg),
    .cfgError (cfgError)
  );

  smr_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .routeCfg      (routeCfg),
    .linkInValid   (linkInValid),
    .linkInData    (inWords),
    .linkOutValid  (linkOutValid),
    .linkOutData   (outWords),
    .coreSendWr    (coreSendWr),
    .coreSendData  (sendWords),
    .coreRecvValid (coreRecvValid),
    .coreRecvData  (recvWords)
  );
endmodule

// File: tb/static_mesh_router_bench.sv
`timescale 1ns/1ps
module static_mesh_router_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0, cfgEn = 1'b0, cfgClear = 1'b0;
  logic [1:0] cfgDir = '0, cfgSel = '0;
  logic cfgError;
  logic [3:0] linkInValid = '0, linkOutValid, coreSendWr = '0, coreRecvValid;
  logic [4*W-1:0] linkInData = '0, linkOutData, coreSendData = '0, coreRecvData;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  static_mesh_router #(.DATA_W(W)) u_static_mesh_router (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgDir(cfgDir), .cfgSel(cfgSel),
    .cfgEn(cfgEn), .cfgClear(cfgClear), .cfgError(cfgError),
    .linkInValid(linkInValid), .linkInData(linkInData),
    .linkOutValid(linkOutValid), .linkOutData(linkOutData),
    .coreSendWr(coreSendWr), .coreSendData(coreSendData),
    .coreRecvValid(coreRecvValid), .coreRecvData(coreRecvData));

  typedef struct packed {
    logic [3:0]     inVld;
    logic [4*W-1:0] inData;   // {west, south, east, north}
    logic [3:0]     outVld;
    logic [4*W-1:0] outData;
  } vec_t;

  // route set A: N<-S, E<-W, S<-local send, W<-N
  localparam vec_t VECS [4] = '{
    '{4'b1111, {32'h44443333, 32'h33332222, 32'h22221111, 32'h11110000},
      4'b1011, {32'h11110000, 32'h0,        32'h44443333, 32'h33332222}},
    '{4'b0101, {32'h12345678, 32'h0F0F0F0F, 32'hDEADBEEF, 32'hA5A5A5A5},
      4'b1001, {32'hA5A5A5A5, 32'h0,        32'h0,        32'h0F0F0F0F}},
    '{4'b1010, {32'h80000000, 32'h00000001, 32'hCAFEF00D, 32'hFFFFFFFF},
      4'b0010, {32'h0,        32'h0,        32'h80000000, 32'h0}},
    '{4'b0000, {32'h9999AAAA, 32'hBBBBCCCC, 32'hDDDDEEEE, 32'h12121212},
      4'b0000, {32'h0,        32'h0,        32'h0,        32'h0}}
  };

  task automatic chk(input bit ok, input string req, input logic [4*W-1:0] act,
                     input logic [4*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic cfgWrite(input logic [1:0] dir, input logic [1:0] sel, input logic en);
    cfgWrEn = 1'b1; cfgDir = dir; cfgSel = sel; cfgEn = en;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic drive(input logic [3:0] vld, input logic [4*W-1:0] data);
    linkInValid = vld; linkInData = data;
    @(negedge clk);
    linkInValid = '0; linkInData = '0;
  endtask

  function automatic logic [4*W-1:0] maskWords(input logic [3:0] vld, input logic [4*W-1:0] d);
    logic [4*W-1:0] r;
    for (int i = 0; i < 4; i++) r[i*W +: W] = vld[i] ? d[i*W +: W] : '0;
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    chk(linkOutValid == 0 && coreRecvValid == 0, "R1 valids in reset", {linkOutValid, coreRecvValid}, 0);
    chk(linkOutData == 0 && coreRecvData == 0 && !cfgError, "R1 data/error in reset",
        linkOutData | coreRecvData, 0);
    @(negedge clk); rstN = 1'b1; @(negedge clk);
    chk(linkOutValid == 0 && !cfgError, "R1 after reset", {cfgError, linkOutValid}, 0);

    // R3 unconfigured outputs stay quiet; R7 receive registers capture
    drive(4'b1111, {32'h01010101, 32'h02020202, 32'h03030303, 32'h04040404});
    chk(linkOutValid == 0 && linkOutData == 0, "R3 disabled outputs", linkOutData, 0);
    chk(coreRecvValid == 4'b1111 && coreRecvData == {32'h01010101, 32'h02020202, 32'h03030303, 32'h04040404},
        "R7 receive capture", coreRecvData, {32'h01010101, 32'h02020202, 32'h03030303, 32'h04040404});

    // R2 route set A
    cfgWrite(2'd0, 2'd2, 1'b1);
    cfgWrite(2'd1, 2'd2, 1'b1);
    cfgWrite(2'd2, 2'd0, 1'b1);
    cfgWrite(2'd3, 2'd1, 1'b1);
    chk(!cfgError, "R2 clean configuration no error", cfgError, 0);

    // R4 R10 R3 R7 table walk
    foreach (VECS[i]) begin
      drive(VECS[i].inVld, VECS[i].inData);
      chk(linkOutValid == VECS[i].outVld, "R4/R10 vector out valid", linkOutValid, VECS[i].outVld);
      chk(linkOutData == VECS[i].outData, "R4/R10 vector out data", linkOutData, VECS[i].outData);
      chk(coreRecvValid == VECS[i].inVld, "R7 vector recv valid", coreRecvValid, VECS[i].inVld);
      chk(coreRecvData == maskWords(VECS[i].inVld, VECS[i].inData), "R7 vector recv data",
          coreRecvData, maskWords(VECS[i].inVld, VECS[i].inData));
    end

    // R6 local injection on south, plus a north send that must not leak
    coreSendWr = 4'b0101;
    coreSendData = {32'h0, 32'hC0DE0002, 32'h0, 32'hBAD00001};
    @(negedge clk);
    coreSendWr = '0; coreSendData = '0;
    chk(linkOutValid == 0, "R6 not out after one edge", linkOutValid, 0);
    @(negedge clk);
    chk(linkOutValid == 4'b0100 && linkOutData == {32'h0, 32'hC0DE0002, 64'h0},
        "R6 local word on south link", linkOutData, {32'h0, 32'hC0DE0002, 64'h0});
    @(negedge clk);
    chk(linkOutValid == 0, "R6 single valid cycle", linkOutValid, 0);

    // R8 same-selector rewrite and disable are silent
    cfgWrite(2'd3, 2'd1, 1'b1);
    chk(!cfgError, "R8 same selector rewrite", cfgError, 0);
    cfgWrite(2'd3, 2'd1, 1'b0);
    chk(!cfgError, "R8 disable write", cfgError, 0);
    drive(4'b0001, {96'h0, 32'h600D0001});
    chk(linkOutValid[3] == 1'b0 && linkOutData[3*W +: W] == 0, "R3 west disabled after write",
        linkOutData, 0);
    cfgWrite(2'd1, 2'd3, 1'b1);
    chk(cfgError, "R8 merge attempt flags", cfgError, 1);
    @(negedge clk);
    chk(cfgError, "R8 error sticky", cfgError, 1);

    // R9 clear
    cfgClear = 1'b1; @(negedge clk); cfgClear = 1'b0;
    chk(!cfgError, "R9 clear drops error", cfgError, 0);
    drive(4'b1111, {32'h1, 32'h2, 32'h3, 32'h4});
    chk(linkOutValid == 0 && linkOutData == 0, "R9 all outputs disabled", linkOutData, 0);

    // R9 clear overrides a write in the same cycle
    cfgClear = 1'b1; cfgWrEn = 1'b1; cfgDir = 2'd0; cfgSel = 2'd2; cfgEn = 1'b1;
    @(negedge clk);
    cfgClear = 1'b0; cfgWrEn = 1'b0;
    drive(4'b0100, {32'h0, 32'h5EED0003, 64'h0});
    chk(linkOutValid == 0 && linkOutData == 0, "R9 clear beats write", linkOutData, 0);

    // R5 fan-out of north onto east, south, west
    cfgWrite(2'd1, 2'd3, 1'b1);
    cfgWrite(2'd2, 2'd2, 1'b1);
    cfgWrite(2'd3, 2'd1, 1'b1);
    chk(!cfgError, "R5 fan-out config no error", cfgError, 0);
    drive(4'b0101, {32'h0, 32'h77777777, 32'h0, 32'h5A5A0001});
    chk(linkOutValid == 4'b1110, "R5 fan-out valids", linkOutValid, 4'b1110);
    chk(linkOutData == {32'h5A5A0001, 32'h5A5A0001, 32'h5A5A0001, 32'h0}, "R5 fan-out data",
        linkOutData, {32'h5A5A0001, 32'h5A5A0001, 32'h5A5A0001, 32'h0});

    summary();
    $finish;
  end
endmodule